// File: doc/BRIEF.md
# Linear Array Readout Control Logic

This block sequences the readout of a 102-element linear photodiode array whose pixels share one analog output. It has two inputs besides reset: a clock and a one-cycle start pulse. A start pulse sampled high while the block is idle does three things at the same edge. It raises a global hold that stops integration on every pixel at once. It opens a fixed integrator reset window. It launches a single token into a chain of select stages, and that token then moves one pixel per clock.

Each pixel's select line routes that pixel's held sample onto the shared output, and an output enable marks the whole output phase. The clock edge that would move the token past the last pixel instead retires it. That edge drops the enable, so the output returns to high impedance, and it releases the hold. A start pulse that arrives while a readout is in progress is discarded. A start input that is high on two edges in a row raises an error pulse. The analog parts are not modelled; the block only drives the control lines they would receive. All pins are plain control pins; there is no data stream and no handshake.

Top module: `lra_readout_ctrl`

## Requirements
- R1: While the asynchronous reset is low, and immediately when it is asserted, all select bits, the hold, the integrator reset, the output enable and the error flag are 0, which is the integrating idle state. The memory of the previous start sample is also cleared, so the first start after reset raises no error.
- R2: When the start input is sampled high at a rising edge while no select bit is set, then after that edge select bit 0 (pixel 1) is 1 and the hold, the output enable and the integrator reset are all 1.
- R3: After each later edge the token moves from select bit i to bit i+1, where bit i drives pixel i+1. No more than one select bit is ever 1.
- R4: The integrator reset stays 1 for exactly 18 clock cycles after the launch edge. It falls after the 18th edge that follows the launch edge, when the token sits on bit 18, and it is 0 at all other times.
- R5: The hold and the output enable stay 1 while the token is on bits 0 to 101. The 102nd edge after the launch edge (the cycle's 103rd clock) clears every select bit and drops the hold and the output enable to 0.
- R6: A start input sampled high while any select bit is set, including on the edge that retires the token from bit 101, has no effect on the select, hold, reset-window or enable outputs. A start sampled high on the next edge after that starts a new cycle.
- R7: The error flag is 1 for exactly one cycle after any edge at which the start input is high and was also high at the previous edge. Otherwise the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_in | input | 1 | Serial start pulse, expected high for one edge |
| pix_sel | output | 102 | One-hot pixel select; bit i routes pixel i+1 to the output |
| hold_smp | output | 1 | Global hold: 1 = all sampling paths detached from integrators |
| integ_rst | output | 1 | Integrator reset window |
| out_en | output | 1 | Output drive enable; 0 = output high impedance |
| dbl_start_err | output | 1 | One-cycle pulse when start is high on two consecutive edges |

## Verification
The first pattern is a lone start pulse with idle time on each side. It checks the full 103-clock sequence edge by edge and shows whether the reset window and the end of the cycle fall on the right edges. Start pulses are then placed at several points inside a readout, including the retiring edge. Each is followed by a start on the first idle edge, which separates correct discarding from a token that is re-launched, doubled, or launched one edge too early or too late. A start held high for two and for four edges checks the error pulse and shows that only one token is launched. A reset in the middle of a cycle, with a start sampled just before it, checks the asynchronous clear and that the previous start sample is forgotten.

// File: rtl/lra_pkg.sv
package lra_pkg;
  localparam int unsigned LRA_NPIX    = 102;
  localparam int unsigned LRA_RST_CYC = 18;
endpackage

// File: rtl/lra_token_chain.sv
// One-hot select chain: stage 0 loads the launch bit, every other stage
// copies its lower neighbour; the token falls off the top stage.
module lra_token_chain #(
  parameter int unsigned NSTG = lra_pkg::LRA_NPIX
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  output logic [NSTG-1:0] sel
);
  logic [NSTG-1:0] sel_nxt;

  generate
    for (genvar g = 0; g < NSTG; g++) begin : g_stage
      if (g == 0) begin : g_head
        assign sel_nxt[g] = launch;
      end else begin : g_body
        assign sel_nxt[g] = sel[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel <= '0;
    else        sel <= sel_nxt;
  end
endmodule

// File: rtl/lra_rst_window.sv
// Down-counter that keeps the integrator reset active for WIN cycles
// after a launch edge.
module lra_rst_window #(
  parameter int unsigned WIN = lra_pkg::LRA_RST_CYC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic active
);
  localparam int unsigned CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LOAD = CW'(WIN);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (launch)         remain <= LOAD;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign active = (remain != '0);
endmodule

// File: rtl/lra_start_gate.sv
// Qualifies the start input against the busy state and flags a start
// that stays high across two edges.
module lra_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic start_in,
  input  logic busy,
  output logic launch,
  output logic dbl_err
);
  logic start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      dbl_err <= 1'b0;
    end else begin
      start_q <= start_in;
      dbl_err <= start_in & start_q;
    end
  end

  assign launch = start_in & ~busy;
endmodule

// File: rtl/lra_readout_ctrl.sv
module lra_readout_ctrl #(
  parameter int unsigned NPIX    = lra_pkg::LRA_NPIX,
  parameter int unsigned RST_CYC = lra_pkg::LRA_RST_CYC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_in,
  output logic [NPIX-1:0] pix_sel,
  output logic            hold_smp,
  output logic            integ_rst,
  output logic            out_en,
  output logic            dbl_start_err
);
  logic busy;
  logic launch;

  lra_start_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_in (start_in),
    .busy     (busy),
    .launch   (launch),
    .dbl_err  (dbl_start_err)
  );

  lra_token_chain #(.NSTG(NPIX)) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .sel    (pix_sel)
  );

  lra_rst_window #(.WIN(RST_CYC)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .active (integ_rst)
  );

  // A readout is in progress exactly while a token is in the chain.
  assign busy     = |pix_sel;
  assign hold_smp = busy;
  assign out_en   = busy;
endmodule

// File: rtl/lra_readout_ctrl_chk.sv
module lra_readout_ctrl_chk #(
  parameter int unsigned NPIX    = 102,
  parameter int unsigned RST_CYC = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_in,
  input logic [NPIX-1:0] pix_sel,
  input logic            hold_smp,
  input logic            integ_rst,
  input logic            out_en,
  input logic            dbl_start_err
);
  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (start_in && pix_sel == '0) |=> (pix_sel[0] && hold_smp && out_en && integ_rst));

  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pix_sel));

  a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (|pix_sel[NPIX-2:0]) |=> (pix_sel[NPIX-1:1] == $past(pix_sel[NPIX-2:0])));

  a_r4_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(integ_rst) |-> pix_sel[0]);

  a_r4_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(integ_rst) |-> pix_sel[RST_CYC]);

  a_r5_end: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sel[NPIX-1] |=> (pix_sel == '0 && !out_en && !hold_smp));

  a_r6_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (|pix_sel) |=> !pix_sel[0]);

  a_r7_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (start_in && $past(start_in)) |=> dbl_start_err);

  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !start_in |=> !dbl_start_err);
endmodule

bind lra_readout_ctrl lra_readout_ctrl_chk #(.NPIX(NPIX), .RST_CYC(RST_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_in      (start_in),
  .pix_sel       (pix_sel),
  .hold_smp      (hold_smp),
  .integ_rst     (integ_rst),
  .out_en        (out_en),
  .dbl_start_err (dbl_start_err)
);

// File: tb/lra_readout_ctrl_tb.sv
module lra_readout_ctrl_tb;
  localparam int N = 102;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_in = 1'b0;
  logic [N-1:0] pix_sel;
  logic         hold_smp, integ_rst, out_en, dbl_start_err;

  always #2 clk = ~clk;

  lra_readout_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .pix_sel(pix_sel),
    .hold_smp(hold_smp), .integ_rst(integ_rst), .out_en(out_en),
    .dbl_start_err(dbl_start_err)
  );

  typedef struct {
    logic [N-1:0] sel;
    logic         hold;
    logic         irst;
    logic         oe;
    logic         err;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   pos    = -1;
  bit   prev_s = 1'b0;

  task automatic chk1(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chkv(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pix_sel actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Driver: sets start for the next edge and queues the outputs expected after it.
  task automatic drive(bit s);
    exp_t e;
    string tag;
    @(negedge clk);
    start_in = s;
    tag = "R3";
    if (pos < 0) begin
      if (s) begin pos = 0; tag = "R2"; end
    end else begin
      if (s) tag = "R6";
      if (pos == N-1) begin
        pos = -1;
        if (!s) tag = "R5";
      end else begin
        pos++;
      end
    end
    e.sel  = (pos >= 0) ? ({{(N-1){1'b0}}, 1'b1} << pos) : '0;
    e.hold = (pos >= 0);
    e.oe   = (pos >= 0);
    e.irst = (pos >= 0) && (pos < W);
    e.err  = s && prev_s;
    e.tag  = tag;
    prev_s = s;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0);
  endtask

  task automatic check_reset_state();
    chkv("R1", pix_sel, '0);
    chk1("R1", "hold_smp", hold_smp, 1'b0);
    chk1("R1", "integ_rst", integ_rst, 1'b0);
    chk1("R1", "out_en", out_en, 1'b0);
    chk1("R1", "dbl_start_err", dbl_start_err, 1'b0);
  endtask

  task automatic reset_now();
    @(posedge clk);
    #2;
    start_in = 1'b0;
    rst_n = 1'b0;
    #1;
    check_reset_state();
    pos = -1;
    prev_s = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: pops one expected item per edge and compares after the edge.
  initial begin : mon
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chkv(e.tag, pix_sel, e.sel);
        chk1((e.tag == "R2") ? "R2" : "R5", "hold_smp", hold_smp, e.hold);
        chk1((e.tag == "R2") ? "R2" : "R5", "out_en", out_en, e.oe);
        chk1("R4", "integ_rst", integ_rst, e.irst);
        chk1("R7", "dbl_start_err", dbl_start_err, e.err);
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_reset_state();                       // R1 at power-up
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R4 R5: lone start pulse, full sequence
    drive(1'b1); idle(110);

    // R6: start in mid-cycle ignored
    drive(1'b1); idle(30); drive(1'b1); idle(80);

    // R7 R6: start held two edges
    drive(1'b1); drive(1'b1); idle(110);

    // R6: start on the retiring (103rd) edge ignored, no relaunch
    drive(1'b1); idle(101); drive(1'b1); drive(1'b0); idle(5);

    // R6: back-to-back launch on the first idle edge
    drive(1'b1); idle(102); drive(1'b1); idle(105);

    // R7: start held four edges
    drive(1'b1); drive(1'b1); drive(1'b1); drive(1'b1); idle(110);

    // R1: reset mid-cycle right after a start sample, then relaunch without error
    drive(1'b1); idle(40); drive(1'b1);
    reset_now();
    drive(1'b1); idle(110);

    wait (q.size() == 0);
    @(posedge clk);
    #2;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule